// File: doc/BRIEF.md
# SDRAM Mode-Setting Sequencer

This block sits on the controller side of an SDRAM interface. It runs the one-time mode-setting sequence the memory needs after power-up. A single start pulse launches the sequence. First comes an all-bank precharge. Next come eight auto-refresh commands. Last comes a mode register write whose address word encodes CAS latency, write-burst behaviour and a burst length of one. The idle gaps between commands come from two small delay codes. The mode word is placed on the address pins shifted left by one for a 16-bit data bus and by two for a 32-bit data bus.

The block assumes the power-on wait of the memory has already elapsed before start is pulsed. Every input here is a plain control pin and no data stream passes through the block, so there is no valid/ready handshake and no back-pressure. Software or a boot controller raises start for one cycle. It then waits for the done pulse, after which ordinary traffic may begin.

Top module: `sdram_modeset_seq`

## Requirements
- R1: While reset (synchronous, active high) is applied and after it is released, the command pins show NOP (cs_n,ras_n,cas_n,we_n = 0,1,1,1), the address is zero, and busy and done are low.
- R2: A start pulse accepted while idle makes the sequencer drive PALL in the following cycle, then exactly eight REF commands, then one MRS command, with no other command in between.
- R3: Between PALL and the first REF, NOP is driven for trp_code+1 cycles.
- R4: Between consecutive REF commands, and between the eighth REF and MRS, NOP is driven for trc_code+1 cycles.
- R5: Exactly one NOP cycle follows MRS. In the cycle after that NOP, done is high for one cycle only and the command stays NOP.
- R6: Encodings are PALL = 0010 with address bit 10 high, REF = 0001 and MRS = 0000, in the order cs_n,ras_n,cas_n,we_n. The address is zero on every cycle except PALL and MRS.
- R7: With wr_single_sel=1, the MRS address is 0x440 (bus32_sel=0, cl3_sel=0), 0x460 (16-bit, CL3), 0x880 (32-bit, CL2) or 0x8C0 (32-bit, CL3).
- R8: With wr_single_sel=0 (burst write), the MRS address is 0x040, 0x060, 0x080 or 0x0C0 for the same four combinations.
- R9: A start pulse that arrives while busy is high is ignored. No second sequence follows the current one.
- R10: The delay codes and mode selects are captured when start is accepted. Changing them during a sequence does not change its gaps or its mode word.
- R11: busy is high from the PALL cycle through the NOP cycle after MRS, and is low in the done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to run the sequence |
| trp_code | input | 2 | Precharge-to-refresh gap code (gap = code+1 cycles) |
| trc_code | input | 2 | Refresh-to-refresh and refresh-to-MRS gap code |
| cl3_sel | input | 1 | 0 selects CAS latency 2, 1 selects CAS latency 3 |
| bus32_sel | input | 1 | 0 selects a 16-bit data bus, 1 a 32-bit data bus |
| wr_single_sel | input | 1 | 1 selects single-location writes, 0 burst writes |
| cs_n | output | 1 | SDRAM chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | 13 | SDRAM address pins |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Four full sequences run with distinct precharge and refresh codes: zero, mid and maximum. Each one checks the gap lengths cycle by cycle, so a swapped code or an off-by-one gap count shows up as a misplaced command. Those runs also cover the four single-write mode words, and four short runs cover the burst-write words. Together they separate a wrong shift, a wrong latency field and a wrong write-burst bit. One run pulses start again and changes every configuration input partway through. That run tells a correctly captured configuration apart from a live one, and an ignored restart apart from a queued one.

// File: rtl/sdram_modeset_pkg.sv
package sdram_modeset_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PALL,
    ST_PGAP,
    ST_REF,
    ST_RGAP,
    ST_MRS,
    ST_MGAP
  } seq_state_t;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } sdram_cmd_t;

  localparam sdram_cmd_t CMD_NOP  = sdram_cmd_t'(4'b0111);
  localparam sdram_cmd_t CMD_PALL = sdram_cmd_t'(4'b0010);
  localparam sdram_cmd_t CMD_REF  = sdram_cmd_t'(4'b0001);
  localparam sdram_cmd_t CMD_MRS  = sdram_cmd_t'(4'b0000);

endpackage

// File: rtl/modeset_word.sv
module modeset_word #(
  parameter int ADDR_W = 13,
  parameter int WB_BIT = 9,
  parameter int CL_LSB = 4,
  parameter int CL_W   = 3
) (
  input  logic              cl3,
  input  logic              bus32,
  input  logic              wr_single,
  output logic [ADDR_W-1:0] word
);
  localparam int SHIFT16 = 1;
  localparam int SHIFT32 = 2;

  logic [ADDR_W-1:0] base;

  always_comb begin
    base                 = '0;
    base[WB_BIT]         = wr_single;
    base[CL_LSB +: CL_W] = cl3 ? CL_W'(3) : CL_W'(2);
  end

  assign word = bus32 ? (base << SHIFT32) : (base << SHIFT16);

endmodule

// File: rtl/modeset_gap_timer.sv
module modeset_gap_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/modeset_ctrl.sv
module modeset_ctrl
  import sdram_modeset_pkg::*;
#(
  parameter int REF_COUNT = 8,
  parameter int CODE_W    = 2,
  parameter int MRS_IDLE  = 1,
  parameter int CNT_W     = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CODE_W-1:0] trp_code,
  input  logic [CODE_W-1:0] trc_code,
  input  logic              cl3_sel,
  input  logic              bus32_sel,
  input  logic              wr_single_sel,
  input  logic              gap_expired,
  output seq_state_t        state,
  output logic              gap_load,
  output logic [CNT_W-1:0]  gap_val,
  output logic              lat_cl3,
  output logic              lat_bus32,
  output logic              lat_wr_single,
  output logic              done
);
  localparam int RC_W = $clog2(REF_COUNT + 1);

  logic [RC_W-1:0]   ref_cnt;
  logic [CODE_W-1:0] trp_lat;
  logic [CODE_W-1:0] trc_lat;

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      ref_cnt       <= '0;
      trp_lat       <= '0;
      trc_lat       <= '0;
      lat_cl3       <= 1'b0;
      lat_bus32     <= 1'b0;
      lat_wr_single <= 1'b0;
      done          <= 1'b0;
    end else begin
      done <= (state == ST_MGAP) && gap_expired;
      case (state)
        ST_IDLE: begin
          if (start) begin
            state         <= ST_PALL;
            ref_cnt       <= '0;
            trp_lat       <= trp_code;
            trc_lat       <= trc_code;
            lat_cl3       <= cl3_sel;
            lat_bus32     <= bus32_sel;
            lat_wr_single <= wr_single_sel;
          end
        end
        ST_PALL: state <= ST_PGAP;
        ST_PGAP: if (gap_expired) state <= ST_REF;
        ST_REF: begin
          ref_cnt <= ref_cnt + 1'b1;
          state   <= ST_RGAP;
        end
        ST_RGAP: begin
          if (gap_expired) begin
            if (ref_cnt == RC_W'(REF_COUNT)) state <= ST_MRS;
            else                              state <= ST_REF;
          end
        end
        ST_MRS:  state <= ST_MGAP;
        ST_MGAP: if (gap_expired) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    gap_load = 1'b0;
    gap_val  = '0;
    case (state)
      ST_PALL: begin gap_load = 1'b1; gap_val = CNT_W'(trp_lat); end
      ST_REF:  begin gap_load = 1'b1; gap_val = CNT_W'(trc_lat); end
      ST_MRS:  begin gap_load = 1'b1; gap_val = CNT_W'(MRS_IDLE - 1); end
      default: ;
    endcase
  end

endmodule

// File: rtl/sdram_modeset_seq.sv
module sdram_modeset_seq
  import sdram_modeset_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int CODE_W    = 2,
  parameter int REF_COUNT = 8,
  parameter int MRS_IDLE  = 1,
  parameter int PALL_BIT  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CODE_W-1:0] trp_code,
  input  logic [CODE_W-1:0] trc_code,
  input  logic              cl3_sel,
  input  logic              bus32_sel,
  input  logic              wr_single_sel,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic              busy,
  output logic              done
);
  localparam int MI_W  = $clog2(MRS_IDLE + 1);
  localparam int CNT_W = (CODE_W > MI_W) ? CODE_W : MI_W;

  seq_state_t        state;
  logic              gap_load;
  logic [CNT_W-1:0]  gap_val;
  logic              gap_expired;
  logic              lat_cl3;
  logic              lat_bus32;
  logic              lat_wr_single;
  logic [ADDR_W-1:0] mode_word;
  sdram_cmd_t        cmd;

  modeset_ctrl #(
    .REF_COUNT(REF_COUNT),
    .CODE_W   (CODE_W),
    .MRS_IDLE (MRS_IDLE),
    .CNT_W    (CNT_W)
  ) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .trp_code     (trp_code),
    .trc_code     (trc_code),
    .cl3_sel      (cl3_sel),
    .bus32_sel    (bus32_sel),
    .wr_single_sel(wr_single_sel),
    .gap_expired  (gap_expired),
    .state        (state),
    .gap_load     (gap_load),
    .gap_val      (gap_val),
    .lat_cl3      (lat_cl3),
    .lat_bus32    (lat_bus32),
    .lat_wr_single(lat_wr_single),
    .done         (done)
  );

  modeset_gap_timer #(.CNT_W(CNT_W)) u_gap (
    .clk     (clk),
    .rst     (rst),
    .load    (gap_load),
    .load_val(gap_val),
    .expired (gap_expired)
  );

  modeset_word #(.ADDR_W(ADDR_W)) u_word (
    .cl3      (lat_cl3),
    .bus32    (lat_bus32),
    .wr_single(lat_wr_single),
    .word     (mode_word)
  );

  always_comb begin
    cmd  = CMD_NOP;
    addr = '0;
    case (state)
      ST_PALL: begin cmd = CMD_PALL; addr[PALL_BIT] = 1'b1; end
      ST_REF:  cmd = CMD_REF;
      ST_MRS:  begin cmd = CMD_MRS; addr = mode_word; end
      default: ;
    endcase
  end

  assign cs_n  = cmd.cs_n;
  assign ras_n = cmd.ras_n;
  assign cas_n = cmd.cas_n;
  assign we_n  = cmd.we_n;
  assign busy  = (state != ST_IDLE);

endmodule

// File: rtl/sdram_modeset_checker.sv
module sdram_modeset_checker #(
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [ADDR_W-1:0] addr,
  input logic              busy,
  input logic              done
);
  logic [3:0] c;
  assign c = {cs_n, ras_n, cas_n, we_n};

  assert_legal_cmd_R6: assert property (@(posedge clk) disable iff (rst)
    (c == 4'b0111) || (c == 4'b0010) || (c == 4'b0001) || (c == 4'b0000));

  assert_pall_bit10_R6: assert property (@(posedge clk) disable iff (rst)
    (c == 4'b0010) |-> addr[10]);

  assert_idle_nop_R1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (c == 4'b0111));

  assert_ref_gap_R4: assert property (@(posedge clk) disable iff (rst)
    (c == 4'b0001) |=> (c == 4'b0111));

  assert_mrs_idle_R5: assert property (@(posedge clk) disable iff (rst)
    (c == 4'b0000) |=> (c == 4'b0111) && busy);

  assert_done_once_R5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_not_busy_R11: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_busy_end_R11: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  assert_start_from_idle_R9: assert property (@(posedge clk) disable iff (rst)
    (c == 4'b0010) |-> (!$past(busy) && $past(start)));

endmodule

bind sdram_modeset_seq sdram_modeset_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk  (clk),
  .rst  (rst),
  .start(start),
  .cs_n (cs_n),
  .ras_n(ras_n),
  .cas_n(cas_n),
  .we_n (we_n),
  .addr (addr),
  .busy (busy),
  .done (done)
);

// File: tb/sim_sdram_modeset_seq.sv
`timescale 1ns/1ps
module sim_sdram_modeset_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [1:0]  trp_code = '0;
  logic [1:0]  trc_code = '0;
  logic        cl3_sel = 1'b0;
  logic        bus32_sel = 1'b0;
  logic        wr_single_sel = 1'b0;
  logic        cs_n, ras_n, cas_n, we_n;
  logic [12:0] addr;
  logic        busy, done;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;
  bit clr_pending = 1'b0;

  localparam logic [3:0] NOP  = 4'b0111;
  localparam logic [3:0] PALL = 4'b0010;
  localparam logic [3:0] REF  = 4'b0001;
  localparam logic [3:0] MRS  = 4'b0000;

  always #4 clk = ~clk;

  sdram_modeset_seq u0 (
    .clk(clk), .rst(rst), .start(start),
    .trp_code(trp_code), .trc_code(trc_code),
    .cl3_sel(cl3_sel), .bus32_sel(bus32_sel), .wr_single_sel(wr_single_sel),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .addr(addr), .busy(busy), .done(done)
  );

  task automatic check_now(string req, logic [3:0] ec, logic [12:0] ea, logic eb, logic ed);
    logic [3:0] ac;
    ac = {cs_n, ras_n, cas_n, we_n};
    n_checks++;
    if (ac !== ec || addr !== ea || busy !== eb || done !== ed) begin
      n_fail++;
      $display("FAIL %s: cmd=%b addr=%h busy=%b done=%b expected cmd=%b addr=%h busy=%b done=%b",
               req, ac, addr, busy, done, ec, ea, eb, ed);
    end
  endtask

  task automatic step(string req, logic [3:0] ec, logic [12:0] ea, logic eb, logic ed);
    @(negedge clk);
    check_now(req, ec, ea, eb, ed);
    if (clr_pending) begin
      start = 1'b0;
      clr_pending = 1'b0;
    end
  endtask

  task automatic run_seq(int trp, int trc, bit cl3, bit b32, bit ws, bit disturb,
                         logic [12:0] exp_mode, string mode_req);
    @(negedge clk);
    trp_code = 2'(trp); trc_code = 2'(trc);
    cl3_sel = cl3; bus32_sel = b32; wr_single_sel = ws;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check_now("R2 PALL R6 bit10", PALL, 13'h400, 1'b1, 1'b0);
    for (int j = 0; j <= trp; j++) step("R3 PALL gap", NOP, '0, 1'b1, 1'b0);
    for (int i = 1; i <= 8; i++) begin
      step("R2 REF", REF, '0, 1'b1, 1'b0);
      for (int j = 0; j <= trc; j++) begin
        step("R4 REF gap", NOP, '0, 1'b1, 1'b0);
        if (disturb && i == 3 && j == 0) begin
          start = 1'b1;
          clr_pending = 1'b1;
          trp_code = ~trp_code; trc_code = ~trc_code;
          cl3_sel = ~cl3_sel; bus32_sel = ~bus32_sel; wr_single_sel = ~wr_single_sel;
        end
      end
    end
    step(disturb ? "R10 MRS word" : mode_req, MRS, exp_mode, 1'b1, 1'b0);
    step("R5 R11 idle after MRS", NOP, '0, 1'b1, 1'b0);
    step("R5 done pulse", NOP, '0, 1'b0, 1'b1);
    step("R5 done single", NOP, '0, 1'b0, 1'b0);
    if (disturb)
      for (int k = 0; k < 4; k++) step("R9 no restart", NOP, '0, 1'b0, 1'b0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check_now("R1 in reset", NOP, '0, 1'b0, 1'b0);
    rst = 1'b0;
    step("R1 after reset", NOP, '0, 1'b0, 1'b0);
    step("R1 idle", NOP, '0, 1'b0, 1'b0);
  endtask

  task automatic t_single_write();
    run_seq(0, 0, 1'b0, 1'b0, 1'b1, 1'b0, 13'h440, "R7 16b CL2");
    run_seq(3, 2, 1'b1, 1'b0, 1'b1, 1'b0, 13'h460, "R7 16b CL3");
    run_seq(1, 3, 1'b0, 1'b1, 1'b1, 1'b0, 13'h880, "R7 32b CL2");
    run_seq(2, 1, 1'b1, 1'b1, 1'b1, 1'b0, 13'h8C0, "R7 32b CL3");
  endtask

  task automatic t_burst_write();
    run_seq(0, 0, 1'b0, 1'b0, 1'b0, 1'b0, 13'h040, "R8 16b CL2");
    run_seq(0, 0, 1'b1, 1'b0, 1'b0, 1'b0, 13'h060, "R8 16b CL3");
    run_seq(0, 0, 1'b0, 1'b1, 1'b0, 1'b0, 13'h080, "R8 32b CL2");
    run_seq(0, 0, 1'b1, 1'b1, 1'b0, 1'b0, 13'h0C0, "R8 32b CL3");
  endtask

  task automatic t_disturb();
    run_seq(1, 2, 1'b1, 1'b0, 1'b1, 1'b1, 13'h460, "R10");
    run_seq(0, 1, 1'b0, 1'b1, 1'b0, 1'b0, 13'h080, "R8 after disturb");
  endtask

  initial begin
    t_reset();
    t_single_write();
    t_burst_write();
    t_disturb();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule